// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Controller

This block sits between the byte-wide register interface of a serial port and its shift registers. It owns two byte queues of sixteen entries, one feeding the transmitter and one filled by the receiver. It also owns a write-only control byte that switches the queues on or off, empties either queue on command, records a DMA-mode flag and selects how many received bytes raise the receive interrupt request.

A control write only programs its flush, DMA and threshold fields when its enable bit is also set in that same write. A flush request acts once and is not stored, and it reaches only the queue, never a shift register. While the queues are off, each path behaves like a single holding byte and the receive request fires on one byte. The two status bits for the interrupt status register mirror the enable state. The interrupt priority encoder and the ready pins lie outside this block.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are off and empty, `dma_mode` is 0, the threshold code is 00, `isr_fifo_bits` is 00, `rx_irq` and `rx_overrun` are 0, and both read-data outputs are 0.
- R2: A control write sets `fifo_en` to bit 0 of the written byte from the next cycle on; `isr_fifo_bits` reads 11 while enabled and 00 while disabled.
- R3: Bits 1, 2, 3, 6 and 7 of a control write take effect only when bit 0 of that same write is 1. Bits 5:4 are ignored in every write.
- R4: A write with bits 0 and 1 set empties the receive queue (`rx_count` 0 on the next cycle) and clears `rx_overrun`. The request is not stored, so later writes without bit 1 do not flush. The transmit queue and `rx_rdata` are untouched, and a receive push or pop in the same cycle is discarded.
- R5: A write with bits 0 and 2 set empties the transmit queue in the same way, leaving the receive queue and `tx_rdata` untouched.
- R6: `dma_mode` takes bit 3 of each write whose bit 0 is 1, and it keeps its value across writes whose bit 0 is 0.
- R7: Bits 7:6 select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. While enabled, `rx_irq` is 1 exactly when `rx_count` is at or above the threshold.
- R8: While enabled, each queue holds up to 16 bytes in first-in first-out order. `*_full` is 1 at 16 entries and `*_empty` is 1 at 0. A pop with data present loads the head byte into `*_rdata` on the next cycle. A push and a pop in one cycle are both accepted when the queue was neither full nor empty before that cycle.
- R9: While disabled, each queue holds at most one byte, `*_full` is 1 at one entry, and `rx_irq` is 1 whenever `rx_count` is at least 1.
- R10: A push to a full queue is dropped and leaves the count unchanged. A dropped receive push sets `rx_overrun`, which stays set until a receive flush or a change of enable.
- R11: A pop from an empty queue leaves `*_rdata` and the count unchanged.
- R12: A control write that changes the enable state empties both queues and clears `rx_overrun` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_wdata | input | DATA_W | Byte to enqueue for transmit |
| tx_pop | input | 1 | Shift register takes the transmit head byte |
| tx_rdata | output | DATA_W | Last byte popped from the transmit queue |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_wdata | input | DATA_W | Received byte |
| rx_pop | input | 1 | Host reads the receive head byte |
| rx_rdata | output | DATA_W | Last byte popped from the receive queue |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_overrun | output | 1 | Sticky flag for a dropped receive byte |
| rx_irq | output | 1 | Receive threshold request |
| fifo_en | output | 1 | Queues enabled |
| dma_mode | output | 1 | DMA-mode flag |
| isr_fifo_bits | output | 2 | Enable status bits for the interrupt status register |

## Verification
The in-design properties assume that reset is held low long enough to clear all state, and that the strobes are clean single-cycle levels sampled at the rising edge. They also allow a push, a pop and a control write in the same cycle, so flush priority is checked against live traffic. The stimulus changes inputs only on the falling edge. It mixes directed sequences with a long stretch in which push, pop and control writes collide freely, including writes that toggle the enable while both queues hold data.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } rx_trig_e;

    typedef struct packed {
        logic     en;
        logic     dma;
        rx_trig_e trig;
    } ctl_state_t;

    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_RXFL_BIT  = 1;
    localparam int unsigned CTL_TXFL_BIT  = 2;
    localparam int unsigned CTL_DMA_BIT   = 3;
    localparam int unsigned CTL_TRIG_LSB  = 6;

    function automatic int unsigned trig_level(rx_trig_e t);
        case (t)
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            TRIG_14: return 14;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fifo_en,
    output logic       dma_mode,
    output rx_trig_e   trig,
    output logic       flush_rx,
    output logic       flush_tx
);

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        flush_rx = 1'b0;
        flush_tx = 1'b0;
        if (wr_en) begin
            state_d.en = wr_data[CTL_EN_BIT];
            if (wr_data[CTL_EN_BIT] != state_q.en) begin
                flush_rx = 1'b1;
                flush_tx = 1'b1;
            end
            if (wr_data[CTL_EN_BIT]) begin
                state_d.dma  = wr_data[CTL_DMA_BIT];
                state_d.trig = rx_trig_e'(wr_data[CTL_TRIG_LSB +: 2]);
                if (wr_data[CTL_RXFL_BIT]) flush_rx = 1'b1;
                if (wr_data[CTL_TXFL_BIT]) flush_tx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{en: 1'b0, dma: 1'b0, trig: TRIG_1};
        end else begin
            state_q <= state_d;
        end
    end

    assign fifo_en  = state_q.en;
    assign dma_mode = state_q.dma;
    assign trig     = state_q.trig;

    // R3
    gated_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CTL_EN_BIT]) |=> ($stable(dma_mode) && $stable(trig)));

    // R2
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fifo_en == $past(wr_data[CTL_EN_BIT])));

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0]     wr_ptr;
        logic [PW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic [DATA_W-1:0] rdata;
    } fifo_state_t;

    fifo_state_t       state_d, state_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [CW-1:0]     cap;
    logic              push_ok;
    logic              pop_ok;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        cap     = en ? CW'(DEPTH) : CW'(1);
        full    = (state_q.count == cap);
        empty   = (state_q.count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        state_d = state_q;
        if (flush) begin
            state_d.wr_ptr = '0;
            state_d.rd_ptr = '0;
            state_d.count  = '0;
        end else begin
            if (pop_ok) begin
                state_d.rdata  = mem_q[state_q.rd_ptr];
                state_d.rd_ptr = ptr_inc(state_q.rd_ptr);
            end
            if (push_ok) begin
                state_d.wr_ptr = ptr_inc(state_q.wr_ptr);
            end
            state_d.count = state_q.count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem_q[state_q.wr_ptr] <= wdata;
        end
    end

    assign rdata = state_q.rdata;
    assign count = state_q.count;

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (count <= CW'(1)));

    // R11
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> ($stable(rdata) && count == '0));

    // R4
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && $stable(rdata)));

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  rx_trig_e                   trig,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       push,
    input  logic                       full,
    input  logic                       flush,
    output logic                       irq,
    output logic                       overrun
);

    localparam int unsigned CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic ovr;
    } stat_state_t;

    stat_state_t   state_d, state_q;
    logic [CW-1:0] level;

    always_comb begin
        level   = en ? CW'(trig_level(trig)) : CW'(1);
        irq     = (count >= level);
        state_d = state_q;
        if (flush) begin
            state_d.ovr = 1'b0;
        end else if (push && full) begin
            state_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign overrun = state_q.ovr;

    // R7
    no_irq_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !irq);

    // R7
    irq_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> irq);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> overrun);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_we,
    input  logic [7:0]                 ctl_wdata,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_wdata,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_rdata,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_empty,
    output logic                       tx_full,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_wdata,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_empty,
    output logic                       rx_full,
    output logic                       rx_overrun,
    output logic                       rx_irq,
    output logic                       fifo_en,
    output logic                       dma_mode,
    output logic [1:0]                 isr_fifo_bits
);

    rx_trig_e trig;
    logic     flush_rx;
    logic     flush_tx;

    uart_fifo_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_we),
        .wr_data  (ctl_wdata),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig     (trig),
        .flush_rx (flush_rx),
        .flush_tx (flush_tx)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fifo_en),
        .flush (flush_tx),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fifo_en),
        .flush (flush_rx),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .empty (rx_empty),
        .full  (rx_full)
    );

    uart_rx_status #(.DEPTH(DEPTH)) u_rx_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (fifo_en),
        .trig    (trig),
        .count   (rx_count),
        .push    (rx_push),
        .full    (rx_full),
        .flush   (flush_rx),
        .irq     (rx_irq),
        .overrun (rx_overrun)
    );

    assign isr_fifo_bits = {2{fifo_en}};

    // R12
    toggle_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != $past(fifo_en)) |-> (tx_count == '0 && rx_count == '0 && !rx_overrun));

endmodule

// File: tb/uart_fifo_ctl_test.sv
module uart_fifo_ctl_test;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]    tx_wdata = '0, rx_wdata = '0;
    logic [7:0]    tx_rdata, rx_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, tx_full, rx_empty, rx_full, rx_overrun, rx_irq;
    logic          fifo_en, dma_mode;
    logic [1:0]    isr_fifo_bits;

    uart_fifo_ctl #(.DEPTH(DEPTH), .DATA_W(8)) uut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] m_txr = '0, m_rxr = '0;
    bit m_en = 0, m_dma = 0, m_ovr = 0;
    int m_lvl = 1;

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL [%s] %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit en_new = ctl_we ? ctl_wdata[0] : m_en;
        bit chg = ctl_we && (ctl_wdata[0] != m_en);
        bit frx = chg || (ctl_we && ctl_wdata[0] && ctl_wdata[1]);
        bit ftx = chg || (ctl_we && ctl_wdata[0] && ctl_wdata[2]);
        int cap = m_en ? DEPTH : 1;
        bit tx_push_ok = tx_push && (txq.size() < cap);
        bit tx_pop_ok  = tx_pop && (txq.size() > 0);
        bit rx_push_ok = rx_push && (rxq.size() < cap);
        bit rx_pop_ok  = rx_pop && (rxq.size() > 0);
        if (ftx) txq.delete();
        else begin
            if (tx_pop_ok) m_txr = txq.pop_front();
            if (tx_push_ok) txq.push_back(tx_wdata);
        end
        if (frx) begin
            rxq.delete();
            m_ovr = 0;
        end else begin
            if (rx_pop_ok) m_rxr = rxq.pop_front();
            if (rx_push_ok) rxq.push_back(rx_wdata);
            if (rx_push && !rx_push_ok) m_ovr = 1;
        end
        m_en = en_new;
        if (ctl_we && ctl_wdata[0]) begin
            m_dma = ctl_wdata[3];
            case (ctl_wdata[7:6])
                2'b00: m_lvl = 1;
                2'b01: m_lvl = 4;
                2'b10: m_lvl = 8;
                default: m_lvl = 14;
            endcase
        end
    endtask

    task automatic compare();
        int cap = m_en ? DEPTH : 1;
        int lvl = m_en ? m_lvl : 1;
        chk("fifo_en R2", int'(fifo_en), int'(m_en));
        chk("isr_fifo_bits R2", int'(isr_fifo_bits), m_en ? 3 : 0);
        chk("dma_mode R6", int'(dma_mode), int'(m_dma));
        chk("tx_count R8", int'(tx_count), txq.size());
        chk("rx_count R8", int'(rx_count), rxq.size());
        chk("tx_empty R8", int'(tx_empty), int'(txq.size() == 0));
        chk("rx_empty R8", int'(rx_empty), int'(rxq.size() == 0));
        chk("tx_full R9", int'(tx_full), int'(txq.size() == cap));
        chk("rx_full R9", int'(rx_full), int'(rxq.size() == cap));
        chk("tx_rdata R11", int'(tx_rdata), int'(m_txr));
        chk("rx_rdata R11", int'(rx_rdata), int'(m_rxr));
        chk("rx_overrun R10", int'(rx_overrun), int'(m_ovr));
        chk("rx_irq R7", int'(rx_irq), int'(rxq.size() >= lvl));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        ctl_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_we = 1; ctl_wdata = v;
        step();
    endtask

    task automatic push_both(int n, int seed);
        for (int i = 0; i < n; i++) begin
            tx_push = 1; tx_wdata = 8'(seed + i);
            rx_push = 1; rx_wdata = 8'(8'hA0 ^ (seed + 3 * i));
            step();
        end
    endtask

    task automatic pop_both(int n);
        for (int i = 0; i < n; i++) begin
            tx_pop = 1; rx_pop = 1;
            step();
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL [watchdog] run did not finish: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare();  // R1 reset state

        phase = "R2 enable";
        wr_ctl(8'h01); wr_ctl(8'h00); wr_ctl(8'h01);

        phase = "R8 fill and drain";
        push_both(16, 5);
        phase = "R10 push to full";
        push_both(2, 77);
        phase = "R8 drain";
        pop_both(16);
        phase = "R11 pop empty";
        pop_both(2);

        phase = "R7 thresholds";
        for (int c = 0; c < 4; c++) begin
            wr_ctl(8'((c << 6) | 1));
            for (int i = 0; i < 15; i++) begin
                rx_push = 1; rx_wdata = 8'(i * 7 + c);
                step();
            end
            wr_ctl(8'((c << 6) | 8'h03));
        end

        phase = "R3 gated fields";
        wr_ctl(8'h49);          // enable, DMA on, threshold 4
        push_both(3, 20);
        wr_ctl(8'hCE);          // bit0 clear: only disables
        wr_ctl(8'h01);
        push_both(5, 40);
        wr_ctl(8'h31);          // reserved bits only, no flush
        wr_ctl(8'h30 | 8'h41);

        phase = "R4 rx flush";
        push_both(4, 60);
        wr_ctl(8'h43);
        wr_ctl(8'h41);          // no stored flush request
        phase = "R5 tx flush";
        push_both(2, 90);
        tx_push = 1; tx_wdata = 8'h5A; rx_pop = 1;
        ctl_we = 1; ctl_wdata = 8'h05;
        step();

        phase = "R6 dma";
        wr_ctl(8'h09); wr_ctl(8'h00); wr_ctl(8'h01);

        phase = "R9 disabled single byte";
        wr_ctl(8'h00);
        push_both(2, 100);
        pop_both(1);
        push_both(1, 110);
        tx_push = 1; tx_wdata = 8'h33; tx_pop = 1;
        rx_push = 1; rx_wdata = 8'h44; rx_pop = 1;
        step();
        pop_both(2);

        phase = "R12 enable change";
        push_both(1, 120);
        wr_ctl(8'h81);
        push_both(10, 130);
        wr_ctl(8'h00);

        phase = "R8 random traffic";
        for (int i = 0; i < 3000; i++) begin
            tx_push = ($urandom_range(0, 3) != 0); tx_wdata = 8'($urandom);
            tx_pop  = ($urandom_range(0, 2) == 0);
            rx_push = ($urandom_range(0, 2) != 0); rx_wdata = 8'($urandom);
            rx_pop  = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 40) == 0) begin
                ctl_we = 1;
                ctl_wdata = ($urandom_range(0, 5) == 0) ? 8'($urandom) : (8'($urandom) & 8'hC9) | 8'h01;
            end
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule